// File: doc/BRIEF.md
# Clock-Sampled Single-Bit DRAM Pin Emulator

This block stands in for a one-bit-wide asynchronous dynamic memory so that a memory controller can be exercised against it. A fast local clock samples the row strobe, the column strobe, the write-enable, a 9-bit multiplexed address and the data-in bit. The block finds the strobe edges in those samples, latches row and column addresses, and keeps the data in an on-chip bit array. The array can be smaller than the full address space. The block drives one data-out bit with a separate output-enable.

The block supports several cycle types, all told apart only by the order of the strobe edges: plain reads, early writes, late writes, read-modify-write, page-mode access within one open row, row-only refresh, and hidden refresh. The access delay is a fixed number of sample clocks. A column strobe that falls while the row strobe is high does nothing to the array. The block counts such strobes in a saturating error counter that is visible on a port.

Top module: `dram_pin_emu`

## Requirements
- R1: After reset, dout_en_o is 0, err_cnt_o is 0 and every cell reads as 0.
- R2: dout_en_o is 0 from the first clock edge that samples cas_ni high. It stays 0 for as long as cas_ni is sampled high.
- R3: In a read cycle (cas_ni falls while ras_ni is low and we_ni is high), dout_en_o rises exactly ACC_DLY+1 edges after the first edge that samples cas_ni low. dout_o then gives the addressed cell and holds that value while dout_en_o stays 1.
- R4: Once driven, the output stays enabled with the same value after ras_ni rises, for as long as cas_ni stays low.
- R5: If we_ni is low when the cas_ni fall is sampled (early write), din_i is stored in the addressed cell. dout_en_o stays 0 for the whole cycle.
- R6: A fall of we_ni while cas_ni is low in a read cycle stores the din_i sampled with that fall. If the output is already driven, it keeps showing the old contents (read-modify-write). If the fall comes before the access delay runs out, the output shows the new value (late write).
- R7: While ras_ni stays low, each new cas_ni fall latches a new column in the same row (page mode).
- R8: A ras_ni low period with no cas_ni fall changes no cell and leaves the output disabled. A ras_ni rise and re-fall while cas_ni stays low (hidden refresh) leaves the driven value and the output-enable unchanged.
- R9: A cas_ni fall sampled while ras_ni is high changes no cell and does not enable the output. Each such fall adds one to err_cnt_o, which saturates at all ones.
- R10: The cell index is {row, column}. The row is the low ROW_W bits of addr_i at the ras_ni fall, and the column is the low COL_W bits at the cas_ni fall. The higher address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| din_i | input | 1 | Write data bit |
| dout_o | output | 1 | Read data bit, meaningful when dout_en_o is 1 |
| dout_en_o | output | 1 | Output drive enable |
| err_cnt_o | output | ERR_W | Saturating count of column strobes seen with the row strobe high |

## Verification
The hardest case to reach from the ports is a write-enable fall whose position relative to the access-delay expiry decides what the output shows. The same sampled strobe edge drives both that choice and the data. The bench places the we_ni fall on chosen negative clock edges, once before and once after the enable rises, and checks the output value and the later readback in each case. Hidden refresh needs a second row-strobe fall in the middle of a driven read. The bench reaches it by changing the row strobe and the address while the column strobe is held low.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_ACCESS = 2'd1,
    CYC_DRIVE  = 2'd2,
    CYC_EWRITE = 2'd3
  } cyc_state_e;
endpackage

// File: rtl/dram_edge_sync.sv
module dram_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_ni,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prv_q;

  for (genvar g = 0; g < N; g++) begin : g_strb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_o[g] <= 1'b1;
        prv_q[g] <= 1'b1;
      end else begin
        lvl_o[g] <= strb_ni[g];
        prv_q[g] <= lvl_o[g];
      end
    end
    assign fall_o[g] = prv_q[g] & ~lvl_o[g];
    assign rise_o[g] = ~prv_q[g] & lvl_o[g];
  end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wd_i,
  output logic             rd_o
);
  logic [DEPTH-1:0] cells_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cells_q <= '0;
    else if (we_i) cells_q[idx_i] <= wd_i;
  end

  assign rd_o = cells_q[idx_i];
endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_emu_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int ACC_DLY = 2,
  parameter int ERR_W   = 8,
  localparam int IDX_W  = ROW_W + COL_W,
  localparam int CNT_W  = $clog2(ACC_DLY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_lvl_i,
  input  logic              cas_lvl_i,
  input  logic              we_lvl_i,
  input  logic              ras_fall_i,
  input  logic              cas_fall_i,
  input  logic              we_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  input  logic              cell_rd_i,
  output logic              cell_we_o,
  output logic [IDX_W-1:0]  cell_idx_o,
  output logic              cell_wd_o,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  cyc_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             dout_q;
  logic [ERR_W-1:0] err_q;

  logic             open_fall, stray_fall, ewrite_now, late_now, in_read;
  logic [COL_W-1:0] col_now;

  assign col_now    = addr_i[COL_W-1:0];
  assign open_fall  = cas_fall_i & ~ras_lvl_i;
  assign stray_fall = cas_fall_i & ras_lvl_i;
  assign ewrite_now = open_fall & ~we_lvl_i;
  assign in_read    = (state_q == CYC_ACCESS) || (state_q == CYC_DRIVE);
  assign late_now   = we_fall_i & ~cas_lvl_i & in_read;

  assign cell_we_o  = ewrite_now | late_now;
  assign cell_wd_o  = din_i;
  // during the strobe edge itself the column comes straight from the pins
  assign cell_idx_o = ewrite_now ? {row_q, col_now} : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (ras_fall_i) row_q <= addr_i[ROW_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CYC_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      dout_q  <= 1'b0;
    end else if (cas_lvl_i) begin
      state_q <= CYC_IDLE;
      en_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (open_fall) begin
      idx_q <= {row_q, col_now};
      if (!we_lvl_i) begin
        state_q <= CYC_EWRITE;
      end else begin
        state_q <= CYC_ACCESS;
        cnt_q   <= CNT_W'(ACC_DLY);
      end
    end else if (state_q == CYC_ACCESS) begin
      if (cnt_q == CNT_W'(1)) begin
        state_q <= CYC_DRIVE;
        en_q    <= 1'b1;
        dout_q  <= cell_rd_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else if (stray_fall && (err_q != '1)) err_q <= err_q + ERR_W'(1);
  end

  assign dout_o    = dout_q;
  assign dout_en_o = en_q & ~cas_lvl_i;
  assign err_cnt_o = err_q;
endmodule

// File: rtl/dram_pin_emu.sv
module dram_pin_emu #(
  parameter int ADDR_W  = 9,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int ACC_DLY = 2,
  parameter int ERR_W   = 8,
  localparam int IDX_W  = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_en_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int STRB_RAS = 0;
  localparam int STRB_CAS = 1;
  localparam int STRB_WE  = 2;

  logic [2:0]        lvl, fall, rise;
  logic [ADDR_W-1:0] addr_q;
  logic              din_q;
  logic              cell_we, cell_wd, cell_rd;
  logic [IDX_W-1:0]  cell_idx;

  dram_edge_sync #(.N(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_ni({we_ni, cas_ni, ras_ni}),
    .lvl_o  (lvl),
    .fall_o (fall),
    .rise_o (rise)
  );

  // address and data sampled in the same stage as the strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else begin
      addr_q <= addr_i;
      din_q  <= din_i;
    end
  end

  dram_cycle_ctrl #(
    .ADDR_W (ADDR_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .ACC_DLY(ACC_DLY),
    .ERR_W  (ERR_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_lvl_i (lvl[STRB_RAS]),
    .cas_lvl_i (lvl[STRB_CAS]),
    .we_lvl_i  (lvl[STRB_WE]),
    .ras_fall_i(fall[STRB_RAS]),
    .cas_fall_i(fall[STRB_CAS]),
    .we_fall_i (fall[STRB_WE]),
    .addr_i    (addr_q),
    .din_i     (din_q),
    .cell_rd_i (cell_rd),
    .cell_we_o (cell_we),
    .cell_idx_o(cell_idx),
    .cell_wd_o (cell_wd),
    .dout_o    (dout_o),
    .dout_en_o (dout_en_o),
    .err_cnt_o (err_cnt_o)
  );

  dram_cell_array #(.IDX_W(IDX_W)) u_array (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cell_we),
    .idx_i (cell_idx),
    .wd_i  (cell_wd),
    .rd_o  (cell_rd)
  );

  logic unused_rise;
  assign unused_rise = ^rise;
endmodule

// File: rtl/dram_pin_emu_chk.sv
module dram_pin_emu_chk #(
  parameter int ADDR_W = 9,
  parameter int ERR_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              we_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              din_i,
  input logic              dout_o,
  input logic              dout_en_o,
  input logic [ERR_W-1:0]  err_cnt_o
);
  p_hiz_cas_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cas_ni) |-> !dout_en_o);

  p_dout_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_o && $past(dout_en_o)) |-> $stable(dout_o));

  p_err_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |-> (err_cnt_o == $past(err_cnt_o) + ERR_W'(1)));

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o)) |->
      ($past(ras_ni, 2) && !$past(cas_ni, 2) && $past(cas_ni, 3)));

  p_en_needs_cas_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_en_o) |-> (!$past(cas_ni) && !$past(cas_ni, 2)));

  logic unused_in;
  assign unused_in = ^{we_ni, addr_i, din_i};
endmodule

bind dram_pin_emu dram_pin_emu_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ras_ni   (ras_ni),
  .cas_ni   (cas_ni),
  .we_ni    (we_ni),
  .addr_i   (addr_i),
  .din_i    (din_i),
  .dout_o   (dout_o),
  .dout_en_o(dout_en_o),
  .err_cnt_o(err_cnt_o)
);

// File: tb/dram_pin_emu_test.sv
module dram_pin_emu_test;
  localparam int ADDR_W = 9;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int D      = 2;
  localparam int ERR_W  = 8;
  localparam int NROW   = 1 << ROW_W;
  localparam int NCOL   = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, din_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic dout_o, dout_en_o;
  logic [ERR_W-1:0] err_cnt_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit model [NROW][NCOL];

  always #2.5 clk = ~clk;

  dram_pin_emu #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W),
                 .ACC_DLY(D), .ERR_W(ERR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o),
    .dout_en_o(dout_en_o), .err_cnt_o(err_cnt_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit pat(int r, int c);
    return bit'((((r * 5 + c * 3) >> 1) ^ (r == c ? 1 : 0)) & 1);
  endfunction

  // junk in upper address bits exercises R10
  function automatic logic [ADDR_W-1:0] mk_addr(int v, int junk);
    return {5'(junk), 4'(v)};
  endfunction

  task automatic open_row(int r);
    addr_i = mk_addr(r, r * 7 + 3);
    ras_ni = 1'b0;
    tick(2);
  endtask

  task automatic close_row();
    ras_ni = 1'b1;
    tick(2);
  endtask

  task automatic rd(int r, int c, string req);
    addr_i = mk_addr(c, c + 11);
    we_ni = 1'b1;
    cas_ni = 1'b0;
    tick(D + 3);
    chk({req, " en"}, int'(dout_en_o), 1);
    chk({req, " data"}, int'(dout_o), int'(model[r][c]));
    cas_ni = 1'b1;
    tick(1);
    chk("R2 off after cas rise", int'(dout_en_o), 0);
    tick(1);
  endtask

  task automatic ewr(int r, int c, bit d);
    addr_i = mk_addr(c, c ^ 5'h15);
    we_ni = 1'b0;
    din_i = d;
    cas_ni = 1'b0;
    tick(D + 3);
    chk("R5 early write keeps output off", int'(dout_en_o), 0);
    cas_ni = 1'b1;
    we_ni = 1'b1;
    tick(2);
    model[r][c] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (model[r, c]) model[r][c] = 1'b0;
    tick(3);
    chk("R1 reset en", int'(dout_en_o), 0);
    chk("R1 reset err", int'(err_cnt_o), 0);
    rst_ni = 1'b1;
    tick(2);

    // R1: untouched cell reads 0; R3 exact latency
    open_row(9);
    addr_i = mk_addr(4, 31);
    cas_ni = 1'b0;
    tick(D + 1);
    chk("R3 not yet enabled", int'(dout_en_o), 0);
    tick(1);
    chk("R3 enabled at delay", int'(dout_en_o), 1);
    chk("R1 reset cell zero", int'(dout_o), 0);
    cas_ni = 1'b1;
    tick(1);
    chk("R2 cas high off", int'(dout_en_o), 0);
    tick(1);
    close_row();

    // R5 R7 R10: fill every cell by page-mode early writes
    for (int r = 0; r < NROW; r++) begin
      open_row(r);
      for (int c = 0; c < NCOL; c++) ewr(r, c, pat(r, c));
      close_row();
    end
    // R3 R7: read back in page mode, rows in reverse order
    for (int r = NROW - 1; r >= 0; r--) begin
      open_row(r);
      for (int c = 0; c < NCOL; c++) rd(r, c, "R7 page read");
      close_row();
    end

    // R4: output persists after ras rises while cas low
    open_row(3);
    addr_i = mk_addr(6, 0);
    cas_ni = 1'b0;
    tick(D + 3);
    ras_ni = 1'b1;
    tick(4);
    chk("R4 en after ras rise", int'(dout_en_o), 1);
    chk("R4 data after ras rise", int'(dout_o), int'(model[3][6]));
    // R8 hidden refresh: new row fall with cas still low
    addr_i = mk_addr(12, 9);
    ras_ni = 1'b0;
    tick(3);
    chk("R8 hidden refresh en", int'(dout_en_o), 1);
    chk("R8 hidden refresh data", int'(dout_o), int'(model[3][6]));
    cas_ni = 1'b1;
    tick(2);
    close_row();

    // R6 read-modify-write: we falls after enable, output keeps old value
    open_row(5);
    addr_i = mk_addr(2, 1);
    cas_ni = 1'b0;
    tick(D + 3);
    chk("R6 rmw read old", int'(dout_o), int'(model[5][2]));
    din_i = ~model[5][2];
    we_ni = 1'b0;
    tick(3);
    chk("R6 rmw output unchanged", int'(dout_o), int'(model[5][2]));
    model[5][2] = ~model[5][2];
    cas_ni = 1'b1;
    we_ni = 1'b1;
    tick(2);
    rd(5, 2, "R6 rmw stored");

    // R6 late write before access delay expires: output shows new data
    addr_i = mk_addr(7, 2);
    cas_ni = 1'b0;
    tick(1);
    din_i = ~model[5][7];
    we_ni = 1'b0;
    tick(D + 3);
    model[5][7] = ~model[5][7];
    chk("R6 late write en", int'(dout_en_o), 1);
    chk("R6 late write data", int'(dout_o), int'(model[5][7]));
    cas_ni = 1'b1;
    we_ni = 1'b1;
    tick(2);
    rd(5, 7, "R6 late write stored");
    close_row();

    // R8 row-only refresh on every row
    for (int r = 0; r < NROW; r++) begin
      addr_i = mk_addr(r, 0);
      ras_ni = 1'b0;
      tick(4);
      chk("R8 refresh output off", int'(dout_en_o), 0);
      ras_ni = 1'b1;
      tick(2);
    end
    open_row(10);
    for (int c = 0; c < NCOL; c++) rd(10, c, "R8 data after refresh");
    close_row();

    // R9: stray column strobes with row strobe high, with we low
    for (int k = 0; k < 3; k++) begin
      addr_i = mk_addr(k, 0);
      we_ni = 1'b0;
      din_i = ~model[0][k];
      cas_ni = 1'b0;
      tick(D + 3);
      chk("R9 stray no output", int'(dout_en_o), 0);
      cas_ni = 1'b1;
      we_ni = 1'b1;
      tick(2);
    end
    chk("R9 err count", int'(err_cnt_o), 3);
    open_row(0);
    for (int c = 0; c < 3; c++) rd(0, c, "R9 cells untouched");
    close_row();
    for (int k = 0; k < 260; k++) begin
      cas_ni = 1'b0;
      tick(2);
      cas_ni = 1'b1;
      tick(2);
    end
    chk("R9 err saturates", int'(err_cnt_o), (263 > 255) ? 255 : 263);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule